// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on an 8-bit host bus and gives three 8-bit general-purpose I/O ports, A, B and C. Port C is handled as two 4-bit halves. The upper half follows the direction group of port A and the lower half follows the group of port B. The host selects the block with an active-low select line. It strobes reads and writes with active-low read and write lines, and a 2-bit address picks one of the three port data registers or the control register.

A mode-set control word fixes the direction of each port group. Output ports hold the last written value in a latch. Input ports pass the pin values straight to the bus when read. A second control-word form forces one chosen bit of port C high or low, so software can toggle a single control line without a read-modify-write. Each pin has its own output-enable bit so that a pad ring can tri-state pins that are set as inputs.

All host strobes are sampled on the rising clock edge. Reads are combinational while the strobes are active.

Top module: `pario_top`

## Requirements
- R1: After synchronous reset the direction register holds the value 8'h9B (every port an input). All output enables are 0, all output latches are 0 and the bus is undriven.
- R2: A control write (address 3) with bit 7 = 1 is a mode set. Bit 4 sets port A, bit 3 sets the upper half of port C, bit 1 sets port B and bit 0 sets the lower half of port C. A 1 means input (enables 0) and a 0 means output (enables all 1). Bits 6:5 and 2 have no effect.
- R3: A mode-set write clears the latches of ports A, B and C to zero at the same edge.
- R4: A write to address 0, 1 or 2 loads the port A, B or C latch at the clock edge. The latch then holds its value after the strobes are released and drives the port's output pins.
- R5: A read of port A or B returns the latch when the port is an output and the live input pins when it is an input.
- R6: A read of port C returns each 4-bit half independently, from the latch or from the pins according to that half's direction.
- R7: A control write with bit 7 = 0 sets port C latch bit number din[3:1] to din[0]. Every other port C bit, bits 6:4 of the word, the direction settings and the other latches are left unchanged.
- R8: dout_oe is 1 only while cs_n and rd_n are both low and the address is 0, 1 or 2. A read at address 3 gives dout = 0 with dout_oe = 0, and dout is 0 whenever dout_oe is 0.
- R9: With cs_n high, a low wr_n changes no latch and no direction.
- R10: When rd_n and wr_n are both low on the same port address, dout shows the latch value from before the write during that cycle, and the new value is stored at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 = port A, 1 = port B, 2 = port C, 3 = control |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Bus drive enable |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A latch output |
| pa_oe | output | 8 | Port A pin output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B latch output |
| pb_oe | output | 8 | Port B pin output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C latch output |
| pc_oe | output | 8 | Port C pin output enables |

## Verification
A read and a write can land on the same port in one cycle when the host lowers both strobes together. The read path sees the latch before the edge, and the write updates it at the edge. The bench provokes this directly by lowering rd_n and wr_n together on an output port. It checks that dout carries the old latch value within the cycle and that the pin outputs carry the new value after the edge. Random traffic also mixes mode sets, single-bit writes and changing pin values, so that reads taken right after a direction change are checked against a bench model.

// File: rtl/pario_pkg.sv
package pario_pkg;
    localparam int PW   = 8;
    localparam int HALF = PW / 2;
    localparam int IDXW = $clog2(PW);

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // direction bits kept from a mode-set word, 1 = input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_t;

    localparam logic [PW-1:0] CTRL_RESET = 8'h9B;

    function automatic dir_t dir_from_word(logic [PW-1:0] w);
        dir_t d;
        d.a_in  = w[4];
        d.cu_in = w[3];
        d.b_in  = w[1];
        d.cl_in = w[0];
        return d;
    endfunction

    function automatic logic [PW-1:0] bit_mask(logic [IDXW-1:0] idx);
        logic [PW-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    // merge pins and latch: input bits come from pins
    function automatic logic [PW-1:0] merge_view(logic [PW-1:0] in_mask,
                                                 logic [PW-1:0] pins,
                                                 logic [PW-1:0] latch);
        return (in_mask & pins) | (~in_mask & latch);
    endfunction
endpackage

// File: rtl/pario_ctrl.sv
module pario_ctrl
    import pario_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [PW-1:0] wdata,
    output dir_t          dir,
    output logic          mode_set,
    output logic          bsr_we
);
    assign mode_set = ctrl_we &  wdata[PW-1];
    assign bsr_we   = ctrl_we & ~wdata[PW-1];

    always_ff @(posedge clk) begin
        if (rst)
            dir <= dir_from_word(CTRL_RESET);
        else if (mode_set)
            dir <= dir_from_word(wdata);
    end
endmodule

// File: rtl/pario_latch.sv
module pario_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr)
                q[i] <= 1'b0;
            else if (mask[i])
                q[i] <= d[i];
        end
    end
endmodule

// File: rtl/pario_rdmux.sv
module pario_rdmux
    import pario_pkg::*;
(
    input  logic          rd_act,
    input  sel_e          sel,
    input  logic [PW-1:0] view_a,
    input  logic [PW-1:0] view_b,
    input  logic [PW-1:0] view_c,
    output logic [PW-1:0] dout,
    output logic          dout_oe
);
    always_comb begin
        dout_oe = rd_act && (sel != SEL_CTRL);
        dout    = '0;
        if (dout_oe) begin
            unique case (sel)
                SEL_A:   dout = view_a;
                SEL_B:   dout = view_b;
                SEL_C:   dout = view_c;
                default: dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/pario_top.sv
module pario_top
    import pario_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout,
    output logic          dout_oe,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);
    logic          wr_act, rd_act, ctrl_we, mode_set, bsr_we;
    sel_e          sel;
    dir_t          dir;
    logic [PW-1:0] mask_a, mask_b, mask_c, d_c;
    logic [PW-1:0] inm_a, inm_b, inm_c;

    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n;
    assign sel     = sel_e'(addr);
    assign ctrl_we = wr_act && (sel == SEL_CTRL);

    pario_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .wdata    (din),
        .dir      (dir),
        .mode_set (mode_set),
        .bsr_we   (bsr_we)
    );

    assign mask_a = (wr_act && sel == SEL_A) ? '1 : '0;
    assign mask_b = (wr_act && sel == SEL_B) ? '1 : '0;
    assign mask_c = (wr_act && sel == SEL_C) ? '1 :
                    bsr_we ? bit_mask(din[IDXW:1]) : '0;
    assign d_c    = bsr_we ? {PW{din[0]}} : din;

    pario_latch #(.W(PW)) u_lat_a (
        .clk(clk), .rst(rst), .clr(mode_set), .mask(mask_a), .d(din), .q(pa_out)
    );
    pario_latch #(.W(PW)) u_lat_b (
        .clk(clk), .rst(rst), .clr(mode_set), .mask(mask_b), .d(din), .q(pb_out)
    );
    pario_latch #(.W(PW)) u_lat_c (
        .clk(clk), .rst(rst), .clr(mode_set), .mask(mask_c), .d(d_c), .q(pc_out)
    );

    assign inm_a = {PW{dir.a_in}};
    assign inm_b = {PW{dir.b_in}};
    assign inm_c = {{HALF{dir.cu_in}}, {HALF{dir.cl_in}}};

    assign pa_oe = ~inm_a;
    assign pb_oe = ~inm_b;
    assign pc_oe = ~inm_c;

    pario_rdmux u_rdmux (
        .rd_act  (rd_act),
        .sel     (sel),
        .view_a  (merge_view(inm_a, pa_in, pa_out)),
        .view_b  (merge_view(inm_b, pb_in, pb_out)),
        .view_c  (merge_view(inm_c, pc_in, pc_out)),
        .dout    (dout),
        .dout_oe (dout_oe)
    );
endmodule

// File: rtl/pario_chk.sv
module pario_chk
    import pario_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [1:0]    addr,
    input logic [PW-1:0] din,
    input logic [PW-1:0] dout,
    input logic          dout_oe,
    input logic [PW-1:0] pa_out,
    input logic [PW-1:0] pa_oe,
    input logic [PW-1:0] pb_out,
    input logic [PW-1:0] pb_oe,
    input logic [PW-1:0] pc_out,
    input logic [PW-1:0] pc_oe
);
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!dout_oe && dout == '0)); // R8

    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && addr == 2'd3) |-> (!dout_oe && dout == '0)); // R8

    AST_UNSELECTED_WRITE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                  && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R9

    AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && addr == 2'd3 && din[PW-1])
        |=> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R3

    AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && addr == 2'd3 && !din[PW-1])
        |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out)
             && $stable(pb_out) && $stable(pc_oe) && $stable(pa_oe))); // R7

    AST_OE_WHOLE_GROUP: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1)
        && (pc_oe[7:4] == '0 || pc_oe[7:4] == '1)); // R2
endmodule

bind pario_top pario_chk chk_i (.*);

// File: tb/pario_top_tb_top.sv
`timescale 1ns/1ps
module pario_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    logic [7:0] m_la = 0, m_lb = 0, m_lc = 0;
    logic [3:0] m_dir = 4'hF; // {a, cu, b, cl}, 1 = input

    always #2.5 clk = ~clk;

    pario_top dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] inm_a(); return {8{m_dir[3]}}; endfunction
    function automatic logic [7:0] inm_b(); return {8{m_dir[1]}}; endfunction
    function automatic logic [7:0] inm_c(); return {{4{m_dir[2]}}, {4{m_dir[0]}}}; endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return (inm_a() & pa_in) | (~inm_a() & m_la);
            2'd1: return (inm_b() & pb_in) | (~inm_b() & m_lb);
            2'd2: return (inm_c() & pc_in) | (~inm_c() & m_lc);
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_la = d;
            2'd1: m_lb = d;
            2'd2: m_lc = d;
            default:
                if (d[7]) begin
                    m_dir = {d[4], d[3], d[1], d[0]};
                    m_la = 0; m_lb = 0; m_lc = 0;
                end else begin
                    m_lc[d[3:1]] = d[0];
                end
        endcase
    endfunction

    task automatic check_pins(input string req);
        chk(pa_out == m_la, {req, " pa_out"}, pa_out, m_la);
        chk(pb_out == m_lb, {req, " pb_out"}, pb_out, m_lb);
        chk(pc_out == m_lc, {req, " pc_out"}, pc_out, m_lc);
        chk(pa_oe == ~inm_a(), {req, " pa_oe"}, pa_oe, ~inm_a());
        chk(pb_oe == ~inm_b(), {req, " pb_oe"}, pb_oe, ~inm_b());
        chk(pc_oe == ~inm_c(), {req, " pc_oe"}, pc_oe, ~inm_c());
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = a;
        #1;
        e = exp_read(a);
        chk(dout == e, {req, " dout"}, dout, e);
        chk(dout_oe == (a != 2'd3), {req, " dout_oe"}, {7'd0, dout_oe}, {7'd0, a != 2'd3});
        cs_n = 1; rd_n = 1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2281);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        check_pins("R1");
        chk(dout_oe == 0, "R1 dout_oe", {7'd0, dout_oe}, 8'h00);
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        bus_read(2'd0, "R1 R5 input A");
        bus_read(2'd2, "R1 R6 input C");

        // R2 all outputs, R4 latch and hold
        bus_write(2'd3, 8'h80); check_pins("R2 R3");
        bus_write(2'd0, 8'h3C); check_pins("R4");
        bus_write(2'd1, 8'hA7); check_pins("R4");
        bus_write(2'd2, 8'h81);
        repeat (3) @(negedge clk);
        check_pins("R4 hold");
        bus_read(2'd1, "R5 output B");

        // R8 control read
        bus_read(2'd3, "R8 ctrl read");

        // R9 unselected write
        @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; din = 8'hEE;
        @(negedge clk); wr_n = 1;
        check_pins("R9");
        @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd3; din = 8'h9B;
        @(negedge clk); wr_n = 1;
        check_pins("R9 ctrl");

        // R7 bit set/reset with ignored bits 6:4
        bus_write(2'd3, 8'h7B); check_pins("R7 set bit5");
        bus_write(2'd3, 8'h0A); check_pins("R7 clear bit5");
        bus_write(2'd3, 8'h4F); check_pins("R7 set bit7");

        // R3 mode set clears, R6 mixed halves
        bus_write(2'd3, 8'h88); check_pins("R3 R2 mixed");
        bus_write(2'd2, 8'h3C);
        pc_in = 8'hA5;
        bus_read(2'd2, "R6 mixed C");
        bus_write(2'd3, 8'h81);
        pc_in = 8'h5A;
        bus_read(2'd2, "R6 mixed C swapped");

        // R10 simultaneous read and write
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11);
        @(negedge clk);
        cs_n = 0; rd_n = 0; wr_n = 0; addr = 2'd0; din = 8'h22;
        #1;
        chk(dout == 8'h11, "R10 old value", dout, 8'h11);
        @(negedge clk);
        cs_n = 1; rd_n = 1; wr_n = 1;
        model_write(2'd0, 8'h22);
        check_pins("R10 new value");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [7:0] d;
            r = $urandom % 8;
            d = 8'($urandom);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            if (r < 2) begin
                bus_write(2'd3, d | 8'h80); check_pins("R2 R3 random");
            end else if (r == 2) begin
                bus_write(2'd3, d & 8'h7F); check_pins("R7 random");
            end else if (r < 5) begin
                bus_write(2'(r - 3 + ($urandom % 2)), d); check_pins("R4 random");
            end else begin
                logic [1:0] a;
                a = 2'($urandom);
                bus_read(a, "R5 R6 R8 random");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule